// File: doc/BRIEF.md
# Single-Entry Loop Branch Predictor

This block remembers one taken backward conditional branch and uses it to steer a 32-bit instruction fetch unit that handles mixed 16-bit and 32-bit instructions. When the word being fetched holds the final halfword of the remembered branch, the next fetch address becomes the branch target. The fetched stream therefore looks as if the branch were followed directly by its destination, and the one-cycle bubble of a taken loop branch goes away. Each fetched word carries a tag that marks whether it was redirected. A halfword-valid mask trims the halfwords that fall outside the predicted path, on both sides of the redirected word boundary.

On the execute side, the block takes the resolved branch and returns the information needed to recover. It reads the predicted flag from the tag of the instruction's last halfword, inverts the branch comparison when that flag is set, and swaps the branch offset for the instruction length. A predicted branch that really falls through therefore jumps to its fall-through address. The block also decides when the entry is written and when it is dropped.

Fetch requests use a valid/ready handshake. A fetch counts only in a cycle where `fetch_valid` and `fetch_ready` are both high. The block never stalls the fetcher. When the fetcher back-pressures (`fetch_ready` low), the per-word tag, the mask and the pending low-halfword trim all hold their values. `next_fetch_addr` is combinational and is meant to be loaded on an accepted fetch. The trap-entry event uses its own `trap_valid`/`trap_ready` pair and counts only when both are high.

Top module: `loop_predictor`

## Requirements
- R1: After reset the entry is empty. No fetch address hits, `word_pred_tag` is 0 and `word_hw_valid` is 2'b11 (bit 1 = upper halfword, bit 0 = lower halfword).
- R2: When `ex_valid` is high and the final branch decision is taken, the offset is negative (`ex_imm` MSB set) and the branch was not predicted, the entry is written on that clock edge. The stored source is the address of the branch's last halfword: `ex_pc`+2 when `ex_instr_lo` is 2'b11 (32-bit), otherwise `ex_pc`. The stored target is `ex_pc`+`ex_imm` with bit 0 cleared.
- R3: The entry is invalidated on `fence_i`, on an accepted trap (`trap_valid` and `trap_ready`), and when `ex_valid` shows a predicted branch whose final decision is taken, which means it really fell through. A trap that is not accepted, or a predicted branch that is not taken, leaves the entry intact.
- R4: When a write and an invalidate fall in the same cycle, the write takes effect and the entry stays valid.
- R5: `fetch_hit` is high exactly when the entry is valid and `fetch_addr[31:2]` equals the stored source bits [31:2]. `next_fetch_addr` is then the stored target with bits [1:0] cleared, and otherwise `fetch_addr`+4.
- R6: On each accepted fetch, `word_pred_tag` takes the value of `fetch_hit`. `word_hw_valid` bit 1 drops when the fetch hits and source bit 1 is 0. `word_hw_valid` bit 0 drops when the previous accepted fetch hit with target bit 1 set. Without an accepted fetch, both outputs hold.
- R7: The predicted flag is `ex_hw_tag[1]` for a 32-bit instruction and `ex_hw_tag[0]` for a 16-bit one. `ex_taken` is `ex_cmp_raw` XOR that flag.
- R8: For a predicted branch, `ex_offset` is 4 (32-bit) or 2 (16-bit). Otherwise it is `ex_imm`. `ex_target` is `ex_pc`+`ex_offset` with bit 0 cleared.
- R9: A forward taken branch, a not-taken branch and a correctly predicted branch never write the entry.
- R10: With `ENABLE`=0 the entry never becomes valid, nothing hits, `ex_taken` equals `ex_cmp_raw` and `ex_offset` equals `ex_imm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_addr | input | AW | Address of the word being requested |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | input | 1 | Fetch request accepted by the bus |
| fetch_hit | output | 1 | Current fetch word holds the learned branch end |
| next_fetch_addr | output | AW | Address to fetch after an accepted fetch |
| word_pred_tag | output | 1 | Last accepted word was redirected |
| word_hw_valid | output | 2 | Halfword-valid mask of last accepted word |
| ex_valid | input | 1 | A conditional branch resolves in execute |
| ex_pc | input | AW | Address of the resolving branch |
| ex_instr_lo | input | 2 | Low two instruction bits (2'b11 = 32-bit) |
| ex_hw_tag | input | 2 | Predicted tags of the instruction's halfwords |
| ex_imm | input | AW | Encoded branch offset |
| ex_cmp_raw | input | 1 | Raw branch comparison result |
| fence_i | input | 1 | Instruction-fetch fence executes |
| trap_valid | input | 1 | Trap entry requested |
| trap_ready | input | 1 | Trap entry accepted |
| ex_taken | output | 1 | Final branch decision after inversion |
| ex_offset | output | AW | Offset used for the jump address |
| ex_target | output | AW | Jump address, bit 0 cleared |

## Verification
The assertions assume that `ex_valid`, `fence_i` and the trap pair stay low while reset is held. A write seen in the reset cycle would otherwise be checked against a register that reset still clears. They also assume the fetcher changes `fetch_valid`/`fetch_ready` only between clock edges. The stimulus changes every input just after a rising edge, keeps all event inputs low until reset is released, and holds `ex_valid` low during the table of combinational execute vectors, so those vectors leave the entry untouched.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef logic [1:0] hw_mask_t;
  localparam hw_mask_t HW_BOTH = 2'b11;

  function automatic logic is_wide(input logic [1:0] lo);
    return lo == 2'b11;
  endfunction
endpackage

// File: rtl/lp_entry.sv
module lp_entry #(
  parameter int AW     = 32,
  parameter bit ENABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_src,
  input  logic [AW-1:0] wr_tgt,
  input  logic          inval,
  output logic          valid_q,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] tgt_q
);
  generate
    if (ENABLE) begin : g_on
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          src_q   <= '0;
          tgt_q   <= '0;
        end else if (wr_en) begin
          valid_q <= 1'b1;
          src_q   <= wr_src;
          tgt_q   <= wr_tgt;
        end else if (inval) begin
          valid_q <= 1'b0;
        end
      end

      p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q && src_q == $past(wr_src) && tgt_q == $past(wr_tgt));
      p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inval && !wr_en |=> !valid_q);
      p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && inval |=> valid_q);
    end else begin : g_off
      always_comb begin
        valid_q = 1'b0;
        src_q   = '0;
        tgt_q   = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/lp_fetch.sv
module lp_fetch
  import lp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_addr,
  input  logic          accept,
  input  logic          valid_q,
  input  logic [AW-1:0] src_q,
  input  logic [AW-1:0] tgt_q,
  output logic          hit,
  output logic [AW-1:0] next_addr,
  output logic          tag_q,
  output hw_mask_t      mask_q
);
  logic lo_skip_q;
  logic unused_bits;

  assign unused_bits = ^{src_q[0], tgt_q[0]};
  assign hit = valid_q && (fetch_addr[AW-1:2] == src_q[AW-1:2]);
  assign next_addr = hit ? {tgt_q[AW-1:2], 2'b00} : fetch_addr + AW'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q     <= 1'b0;
      mask_q    <= HW_BOTH;
      lo_skip_q <= 1'b0;
    end else if (accept) begin
      tag_q     <= hit;
      mask_q    <= {!(hit && !src_q[1]), !lo_skip_q};
      lo_skip_q <= hit && tgt_q[1];
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(tag_q) && $stable(mask_q));
  p_upper_only_tagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_q |-> mask_q[1]);
endmodule

// File: rtl/lp_resolve.sv
module lp_resolve
  import lp_pkg::*;
#(
  parameter int AW     = 32,
  parameter bit ENABLE = 1'b1
) (
  input  logic [AW-1:0] pc,
  input  logic [1:0]    instr_lo,
  input  logic [1:0]    hw_tag,
  input  logic [AW-1:0] imm,
  input  logic          cmp_raw,
  output logic          was_pred,
  output logic          taken,
  output logic [AW-1:0] offs,
  output logic [AW-1:0] target,
  output logic [AW-1:0] last_hw_addr
);
  logic          wide;
  logic [AW-1:0] sum;

  assign wide         = is_wide(instr_lo);
  assign was_pred     = ENABLE && (wide ? hw_tag[1] : hw_tag[0]);
  assign taken        = cmp_raw ^ was_pred;
  assign offs         = was_pred ? (wide ? AW'(4) : AW'(2)) : imm;
  assign sum          = pc + offs;
  assign target       = {sum[AW-1:1], 1'b0};
  assign last_hw_addr = pc + (wide ? AW'(2) : AW'(0));
endmodule

// File: rtl/loop_predictor.sv
module loop_predictor
  import lp_pkg::*;
#(
  parameter int AW     = 32,
  parameter bit ENABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_valid,
  input  logic          fetch_ready,
  output logic          fetch_hit,
  output logic [AW-1:0] next_fetch_addr,
  output logic          word_pred_tag,
  output logic [1:0]    word_hw_valid,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_pc,
  input  logic [1:0]    ex_instr_lo,
  input  logic [1:0]    ex_hw_tag,
  input  logic [AW-1:0] ex_imm,
  input  logic          ex_cmp_raw,
  input  logic          fence_i,
  input  logic          trap_valid,
  input  logic          trap_ready,
  output logic          ex_taken,
  output logic [AW-1:0] ex_offset,
  output logic [AW-1:0] ex_target
);
  logic          was_pred;
  logic [AW-1:0] last_hw;
  logic          wr_en;
  logic          inval;
  logic          valid_q;
  logic [AW-1:0] src_q;
  logic [AW-1:0] tgt_q;
  hw_mask_t      mask_q;

  lp_resolve #(.AW(AW), .ENABLE(ENABLE)) u_resolve (
    .pc(ex_pc), .instr_lo(ex_instr_lo), .hw_tag(ex_hw_tag), .imm(ex_imm),
    .cmp_raw(ex_cmp_raw), .was_pred(was_pred), .taken(ex_taken),
    .offs(ex_offset), .target(ex_target), .last_hw_addr(last_hw)
  );

  // Learn only unpredicted taken backward branches; drop on recovery events.
  assign wr_en = ex_valid && ex_taken && ex_imm[AW-1] && !was_pred;
  assign inval = fence_i || (trap_valid && trap_ready) || (ex_valid && was_pred && ex_taken);

  lp_entry #(.AW(AW), .ENABLE(ENABLE)) u_entry (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_src(last_hw), .wr_tgt(ex_target),
    .inval(inval), .valid_q(valid_q), .src_q(src_q), .tgt_q(tgt_q)
  );

  lp_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
    .accept(fetch_valid && fetch_ready), .valid_q(valid_q), .src_q(src_q),
    .tgt_q(tgt_q), .hit(fetch_hit), .next_addr(next_fetch_addr),
    .tag_q(word_pred_tag), .mask_q(mask_q)
  );
  assign word_hw_valid = mask_q;

  p_pred_offs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    was_pred |-> (ex_offset == AW'(2) || ex_offset == AW'(4)));
  p_pred_no_learn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && was_pred && !fence_i |=> !fetch_hit || $stable(next_fetch_addr) || !$stable(fetch_addr));
endmodule

// File: tb/loop_predictor_bench.sv
`timescale 1ns/100ps
module loop_predictor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] fetch_addr = '0;
  logic fetch_valid = 0, fetch_ready = 0;
  logic ex_valid = 0, ex_cmp_raw = 0, fence_i = 0, trap_valid = 0, trap_ready = 0;
  logic [31:0] ex_pc = '0, ex_imm = '0;
  logic [1:0] ex_instr_lo = 2'b11, ex_hw_tag = 2'b00;

  logic fetch_hit, word_pred_tag, ex_taken;
  logic [31:0] next_fetch_addr, ex_offset, ex_target;
  logic [1:0] word_hw_valid;
  logic off_hit, off_tag, off_taken;
  logic [31:0] off_next, off_offset, off_target;
  logic [1:0] off_mask;

  loop_predictor u_loop_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_hit(fetch_hit), .next_fetch_addr(next_fetch_addr),
    .word_pred_tag(word_pred_tag), .word_hw_valid(word_hw_valid), .ex_valid(ex_valid),
    .ex_pc(ex_pc), .ex_instr_lo(ex_instr_lo), .ex_hw_tag(ex_hw_tag), .ex_imm(ex_imm),
    .ex_cmp_raw(ex_cmp_raw), .fence_i(fence_i), .trap_valid(trap_valid),
    .trap_ready(trap_ready), .ex_taken(ex_taken), .ex_offset(ex_offset), .ex_target(ex_target)
  );

  loop_predictor #(.ENABLE(1'b0)) u_off (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_hit(off_hit), .next_fetch_addr(off_next),
    .word_pred_tag(off_tag), .word_hw_valid(off_mask), .ex_valid(ex_valid),
    .ex_pc(ex_pc), .ex_instr_lo(ex_instr_lo), .ex_hw_tag(ex_hw_tag), .ex_imm(ex_imm),
    .ex_cmp_raw(ex_cmp_raw), .fence_i(fence_i), .trap_valid(trap_valid),
    .trap_ready(trap_ready), .ex_taken(off_taken), .ex_offset(off_offset), .ex_target(off_target)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // pc, lo, tag, imm, raw | taken, offset, target  (134 bits)
  localparam logic [133:0] VECS [8] = '{
    {32'h100, 2'b11, 2'b00, 32'hFFFFFFF0, 1'b1, 1'b1, 32'hFFFFFFF0, 32'h0F0},
    {32'h100, 2'b11, 2'b10, 32'hFFFFFFF0, 1'b1, 1'b0, 32'h4,        32'h104},
    {32'h100, 2'b11, 2'b10, 32'hFFFFFFF0, 1'b0, 1'b1, 32'h4,        32'h104},
    {32'h202, 2'b01, 2'b01, 32'hFFFFFFF8, 1'b0, 1'b1, 32'h2,        32'h204},
    {32'h202, 2'b01, 2'b10, 32'h10,       1'b1, 1'b1, 32'h10,       32'h212},
    {32'h300, 2'b11, 2'b01, 32'h20,       1'b0, 1'b0, 32'h20,       32'h320},
    {32'h400, 2'b11, 2'b00, 32'h5,        1'b1, 1'b1, 32'h5,        32'h404},
    {32'h500, 2'b10, 2'b11, 32'h8,        1'b1, 1'b0, 32'h2,        32'h502}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic [1:0] lo, input logic [1:0] tag,
                         input logic [31:0] imm, input logic raw);
    ex_pc = pc; ex_instr_lo = lo; ex_hw_tag = tag; ex_imm = imm; ex_cmp_raw = raw;
    ex_valid = 1;
    step();
    ex_valid = 0;
  endtask

  task automatic accept_at(input logic [31:0] a);
    fetch_addr = a; fetch_valid = 1; fetch_ready = 1;
    step();
    fetch_valid = 0; fetch_ready = 0;
  endtask

  task automatic probe(input string what, input logic [31:0] a, input logic exp_hit,
                       input logic [31:0] exp_next);
    fetch_addr = a;
    #0.5;
    chk({what, " hit"}, {31'b0, fetch_hit}, {31'b0, exp_hit});
    chk({what, " next"}, next_fetch_addr, exp_next);
  endtask

  initial begin
    #50000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();

    // R1: reset state
    probe("R1 empty", 32'h100, 1'b0, 32'h104);
    chk("R1 tag", {31'b0, word_pred_tag}, 0);
    chk("R1 mask", {30'b0, word_hw_valid}, 32'h3);

    // R7 R8: execute-side vectors, ex_valid held low
    foreach (VECS[i]) begin
      ex_pc = VECS[i][133:102]; ex_instr_lo = VECS[i][101:100];
      ex_hw_tag = VECS[i][99:98]; ex_imm = VECS[i][97:66]; ex_cmp_raw = VECS[i][65];
      #0.5;
      chk($sformatf("R7 vec%0d taken", i), {31'b0, ex_taken}, {31'b0, VECS[i][64]});
      chk($sformatf("R8 vec%0d offset", i), ex_offset, VECS[i][63:32]);
      chk($sformatf("R8 vec%0d target", i), ex_target, VECS[i][31:0]);
    end
    probe("R9 vectors did not learn", 32'h100, 1'b0, 32'h104);

    // R2 R5: learn a 32-bit backward branch
    resolve(32'h1C, 2'b11, 2'b00, 32'hFFFFFFE4, 1'b1);
    probe("R5 hit 32b", 32'h1C, 1'b1, 32'h0);
    probe("R5 other word", 32'h18, 1'b0, 32'h1C);
    probe("R2 src in same word", 32'h1E, 1'b1, 32'h0);

    // R6: tag and mask of redirected words
    accept_at(32'h1C);
    chk("R6 tag on hit", {31'b0, word_pred_tag}, 1);
    chk("R6 mask src b1=1", {30'b0, word_hw_valid}, 32'h3);
    accept_at(32'h0);
    chk("R6 tag after", {31'b0, word_pred_tag}, 0);
    chk("R6 mask tgt b1=0", {30'b0, word_hw_valid}, 32'h3);

    // R2 R6: 16-bit branch, target at odd halfword
    resolve(32'h40, 2'b01, 2'b00, 32'hFFFFFFF2, 1'b1);
    probe("R2 16b src", 32'h40, 1'b1, 32'h30);
    probe("R2 old entry replaced", 32'h1C, 1'b0, 32'h20);
    accept_at(32'h40);
    chk("R6 upper trimmed", {30'b0, word_hw_valid}, 32'h1);
    chk("R6 tag 16b", {31'b0, word_pred_tag}, 1);
    accept_at(32'h30);
    chk("R6 lower trimmed", {30'b0, word_hw_valid}, 32'h2);

    // R6: back-pressure holds outputs
    fetch_addr = 32'h40; fetch_valid = 1; fetch_ready = 0;
    step();
    fetch_valid = 0; fetch_ready = 1;
    step();
    fetch_ready = 0;
    chk("R6 hold mask", {30'b0, word_hw_valid}, 32'h2);
    chk("R6 hold tag", {31'b0, word_pred_tag}, 0);

    // R9: no learning from forward, not-taken or correctly predicted branches
    resolve(32'h80, 2'b11, 2'b00, 32'h10, 1'b1);
    probe("R9 forward", 32'h80, 1'b0, 32'h84);
    resolve(32'h90, 2'b11, 2'b00, 32'hFFFFFFF0, 1'b0);
    probe("R9 not taken", 32'h90, 1'b0, 32'h94);
    probe("R9 entry kept", 32'h40, 1'b1, 32'h30);

    // R3: invalidation cases
    resolve(32'h40, 2'b01, 2'b01, 32'hFFFFFFF2, 1'b1);
    probe("R3 correct prediction keeps", 32'h40, 1'b1, 32'h30);
    fence_i = 1; step(); fence_i = 0;
    probe("R3 fence", 32'h40, 1'b0, 32'h44);
    resolve(32'h40, 2'b01, 2'b00, 32'hFFFFFFF2, 1'b1);
    trap_valid = 1; trap_ready = 0; step();
    probe("R3 trap not accepted", 32'h40, 1'b1, 32'h30);
    trap_ready = 1; step(); trap_valid = 0; trap_ready = 0;
    probe("R3 trap accepted", 32'h40, 1'b0, 32'h44);
    resolve(32'h40, 2'b01, 2'b00, 32'hFFFFFFF2, 1'b1);
    resolve(32'h40, 2'b01, 2'b01, 32'hFFFFFFF2, 1'b0);
    probe("R3 mispredict", 32'h40, 1'b0, 32'h44);

    // R4: write beats invalidate
    fence_i = 1;
    resolve(32'h60, 2'b11, 2'b00, 32'hFFFFFFF0, 1'b1);
    fence_i = 0;
    probe("R4 write wins", 32'h60, 1'b1, 32'h50);

    // R10: disabled instance
    fetch_addr = 32'h60;
    ex_pc = 32'h100; ex_instr_lo = 2'b11; ex_hw_tag = 2'b10; ex_imm = 32'hFFFFFFF0; ex_cmp_raw = 1;
    #0.5;
    chk("R10 no hit", {31'b0, off_hit}, 0);
    chk("R10 next seq", off_next, 32'h64);
    chk("R10 no invert", {31'b0, off_taken}, 1);
    chk("R10 offset imm", off_offset, 32'hFFFFFFF0);
    chk("R10 tag", {31'b0, off_tag}, 0);
    chk("R10 mask", {30'b0, off_mask}, 32'h3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule